// File: doc/BRIEF.md
# Four-Lane 3x3 Sobel Gradient Stage

This block sits in a streaming edge-detection pipeline directly after a smoothing stage. It takes grayscale pixels four at a time, packed into one 32-bit word, with a strobe that marks the first word of each frame. Two lines of history are kept in line memories. From each new word, the two stored lines and a few word registers, the block forms a 3-row by 6-column window. That window holds four overlapping 3x3 neighbourhoods, so four gradients are produced per word.

For each of the four centre pixels the block forms the horizontal and vertical Sobel derivatives as signed 11-bit values. It then reduces them to an 8-bit saturated magnitude and a 2-bit direction sector. No multiplier is used: kernel weights and the tangent comparison constants are built from shifts and adds. Results leave one line plus one word behind the input, packed four to a word, with frame-start and line-start strobes aligned to them. After the last word of a frame the block drains itself by running one line plus one word of internal zero input.

Top module: `sobel4_gradient`

## Requirements
- R1: A frame is FRAME_LINES lines of LINE_WORDS words in raster order, and its first word carries in_sof=1. Inside a word, pixel k (k=0..3, pixel 0 leftmost on screen) occupies in_data bits [8k+7:8k].
- R2: For every pixel, Gx is the right column minus the left column of its 3x3 neighbourhood, weighted 1,2,1 from top to bottom. Gy is the lower row minus the upper row, weighted 1,2,1 from left to right.
- R3: Every neighbour above the first line, below the last line, left of the first pixel or right of the last pixel of a line is taken as 0.
- R4: The magnitude of pixel k is min(|Gx|+|Gy|, 255) and is placed on out_mag bits [8k+7:8k].
- R5: The direction of pixel k is placed on out_dir bits [2k+1:2k]. It is 0 when 309·|Gy| < 128·|Gx|. Otherwise it is 2 when 53·|Gy| > 128·|Gx|. Otherwise it is 1 when Gx and Gy have the same sign bit and 3 when their sign bits differ. In particular, Gx=Gy=0 gives 1.
- R6: Exactly one output word is produced per input word. With gap-free input, the result for centre word m of a frame is valid in the cycle after word m+LINE_WORDS+1 of that frame is accepted. No output appears in the cycle after a frame-start word.
- R7: After the last word of a frame, the block produces the remaining LINE_WORDS+1 results on its own, one per cycle, in the following LINE_WORDS+1 cycles. The upstream stage must hold in_valid low during those cycles.
- R8: out_sof is high only with the first result of a frame. out_sol is high with the first result of every line. Both are high only together with out_valid.
- R9: A cycle with in_valid low outside the drain phase pauses the stage: no result follows it, and results after the pause are unchanged.
- R10: After reset, out_valid, out_sof and out_sol are low and out_mag and out_dir are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Input word is the first of a frame |
| in_data | input | 32 | Four packed 8-bit pixels |
| out_valid | output | 1 | Result word present |
| out_sof | output | 1 | Result is the first of a frame |
| out_sol | output | 1 | Result is the first of a line |
| out_mag | output | 32 | Four packed 8-bit gradient magnitudes |
| out_dir | output | 8 | Four packed 2-bit direction sectors |

## Verification
The bench targets the window edges. On a flat white frame, only the border pixels see a gradient. A design that pads wrongly, or that reuses the previous frame's lines as the top neighbours, shows nonzero or wrong values on the first line or first column. Step edges at word and line boundaries catch a window that mixes up the left and right words, or a seam pixel taken from the wrong word. Ramps and random data probe the sector thresholds near 22.5 and 67.5 degrees, where an off-by-one shift sum flips the code. Latency, drain length and paused input are checked against an accepted-word count, so a stage that emits early, drops drain words or advances on idle cycles shows up as misplaced or missing results.

// File: rtl/sobel4_pkg.sv
// Shared constants and types for the four-lane Sobel gradient stage.
// Assumes 8-bit grayscale pixels packed four to a word.
package sobel4_pkg;
    localparam int PIX_W     = 8;
    localparam int LANES     = 4;
    localparam int WORD_W    = PIX_W * LANES;
    localparam int WIN_COLS  = LANES + 2;
    localparam int WIN_ROWS  = 3;
    localparam int GRAD_W    = 11;
    localparam int DIR_W     = 2;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef pix_t [WIN_COLS-1:0] win_row_t;
    typedef win_row_t [WIN_ROWS-1:0] window_t;

    typedef enum logic [DIR_W-1:0] {
        SECT_HORIZ = 2'd0,
        SECT_DIAG_SAME = 2'd1,
        SECT_VERT = 2'd2,
        SECT_DIAG_OPP = 2'd3
    } sector_e;
endpackage

// File: rtl/s4_line_cache.sv
// Line history for the gradient stage. One memory per cached line, each
// LINE_WORDS words deep, chained so that tap i returns the word written
// i lines earlier at the same column. The memory is read before it is
// written in the same step. Assumes every step advances the column by one.
module s4_line_cache
    import sobel4_pkg::*;
#(
    parameter int LINE_WORDS   = 8,
    parameter int CACHED_LINES = 2,
    localparam int ADDR_W      = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input  logic                          clk,
    input  logic                          step,
    input  logic [ADDR_W-1:0]             addr,
    input  word_t                         din,
    output logic [CACHED_LINES:0][WORD_W-1:0] taps
);
    assign taps[0] = din;

    for (genvar i = 0; i < CACHED_LINES; i++) begin : g_line
        word_t mem [LINE_WORDS];

        // Store the word arriving from the line below this one.
        always_ff @(posedge clk) begin
            if (step) begin
                mem[addr] <= taps[i];
            end
        end

        assign taps[i+1] = mem[addr];
    end
endmodule

// File: rtl/s4_window.sv
// Builds the 3-row by 6-column window for four adjacent centre pixels.
// Each of the three line streams keeps two word registers (centre and
// left word); the incoming word supplies the right edge. Out-of-frame
// rows and edge columns are forced to zero by the mask inputs.
// Stream 0 is the newest (lower) line, stream 2 the oldest (upper).
module s4_window
    import sobel4_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step,
    input  logic [WIN_ROWS-1:0][WORD_W-1:0] taps,
    input  logic                          zero_left,
    input  logic                          zero_right,
    input  logic                          zero_top,
    input  logic                          zero_bottom,
    output window_t                       win
);
    logic [WIN_ROWS-1:0][WORD_W-1:0] ctr_q;
    logic [WIN_ROWS-1:0][WORD_W-1:0] lft_q;

    // Shift each stream by one word per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
            lft_q <= '0;
        end else if (step) begin
            ctr_q <= taps;
            lft_q <= ctr_q;
        end
    end

    // Assemble the masked window, row 0 at the top.
    always_comb begin
        for (int r = 0; r < WIN_ROWS; r++) begin
            win[r][0] = zero_left ? '0 : lft_q[WIN_ROWS-1-r][WORD_W-1 -: PIX_W];
            for (int k = 0; k < LANES; k++) begin
                win[r][k+1] = ctr_q[WIN_ROWS-1-r][k*PIX_W +: PIX_W];
            end
            win[r][WIN_COLS-1] = zero_right ? '0 : taps[WIN_ROWS-1-r][PIX_W-1:0];
        end
        if (zero_top) begin
            win[0] = '0;
        end
        if (zero_bottom) begin
            win[WIN_ROWS-1] = '0;
        end
    end
endmodule

// File: rtl/s4_grad_px.sv
// Gradient of one pixel from its 3x3 neighbourhood. Purely combinational.
// Produces a saturated |Gx|+|Gy| magnitude and a 2-bit sector. The
// tangent limits are 309/128 (about 2.414) and 53/128 (about 0.414),
// built from shifts and adds only.
module s4_grad_px
    import sobel4_pkg::*;
(
    input  pix_t [2:0][2:0] nb,
    output pix_t            mag,
    output logic [DIR_W-1:0] dir
);
    localparam int SUM_W = PIX_W + 2;
    localparam int CMP_W = SUM_W + 10;

    logic [SUM_W-1:0]         gx_pos, gx_neg, gy_pos, gy_neg;
    logic signed [GRAD_W-1:0] gx, gy;
    logic [SUM_W-1:0]         ax, ay;
    logic [SUM_W:0]           abs_sum;
    logic [CMP_W-1:0]         ay_hi, ay_lo, ax_sc;

    // Weighted column and row sums, weight 2 by a left shift.
    always_comb begin
        gx_pos = SUM_W'(nb[0][2]) + SUM_W'({nb[1][2], 1'b0}) + SUM_W'(nb[2][2]);
        gx_neg = SUM_W'(nb[0][0]) + SUM_W'({nb[1][0], 1'b0}) + SUM_W'(nb[2][0]);
        gy_pos = SUM_W'(nb[2][0]) + SUM_W'({nb[2][1], 1'b0}) + SUM_W'(nb[2][2]);
        gy_neg = SUM_W'(nb[0][0]) + SUM_W'({nb[0][1], 1'b0}) + SUM_W'(nb[0][2]);
    end

    // Signed derivatives and their absolute values.
    always_comb begin
        gx = signed'({1'b0, gx_pos}) - signed'({1'b0, gx_neg});
        gy = signed'({1'b0, gy_pos}) - signed'({1'b0, gy_neg});
        ax = (gx_pos >= gx_neg) ? (gx_pos - gx_neg) : (gx_neg - gx_pos);
        ay = (gy_pos >= gy_neg) ? (gy_pos - gy_neg) : (gy_neg - gy_pos);
    end

    // Saturated magnitude.
    always_comb begin
        abs_sum = {1'b0, ax} + {1'b0, ay};
        mag     = (abs_sum > (SUM_W+1)'(255)) ? 8'hFF : abs_sum[PIX_W-1:0];
    end

    // Sector decision from shifted-sum tangent limits.
    always_comb begin
        ay_hi = (CMP_W'(ay) << 8) + (CMP_W'(ay) << 5) + (CMP_W'(ay) << 4)
              + (CMP_W'(ay) << 2) + CMP_W'(ay);
        ay_lo = (CMP_W'(ay) << 5) + (CMP_W'(ay) << 4) + (CMP_W'(ay) << 2) + CMP_W'(ay);
        ax_sc = CMP_W'(ax) << 7;
        if (ay_hi < ax_sc) begin
            dir = SECT_HORIZ;
        end else if (ay_lo > ax_sc) begin
            dir = SECT_VERT;
        end else if (gx[GRAD_W-1] == gy[GRAD_W-1]) begin
            dir = SECT_DIAG_SAME;
        end else begin
            dir = SECT_DIAG_OPP;
        end
    end
endmodule

// File: rtl/sobel4_gradient.sv
// Four-lane 3x3 Sobel gradient stage. Accepts four pixels per word and
// emits four magnitudes and sectors per word, one line plus one word
// later. Assumes frames of FRAME_LINES x LINE_WORDS words, with in_sof on
// the first word, and in_valid held low for LINE_WORDS+1 cycles after the
// last word of a frame while the stage drains with zero input.
module sobel4_gradient
    import sobel4_pkg::*;
#(
    parameter int LINE_WORDS  = 8,
    parameter int FRAME_LINES = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic [WORD_W-1:0]        in_data,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic                     out_sol,
    output logic [WORD_W-1:0]        out_mag,
    output logic [LANES*DIR_W-1:0]   out_dir
);
    localparam int COL_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam int ROW_W = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1;
    localparam int LAG_W = $clog2(LINE_WORDS + 2);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(LINE_WORDS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(FRAME_LINES - 1);
    localparam logic [LAG_W-1:0] LAG_FULL  = LAG_W'(LINE_WORDS + 1);
    localparam logic [COL_W:0]   DRAIN_END = (COL_W+1)'(LINE_WORDS);

    logic               flushing;
    logic [COL_W:0]     drain_cnt;
    logic [COL_W-1:0]   pos_col, cur_col, cen_col;
    logic [ROW_W-1:0]   pos_row, cur_row, cen_row;
    logic [LAG_W-1:0]   lag, lag_now;
    logic               take_sof, step, emit, last_in;
    word_t              step_data;
    logic [WIN_ROWS-1:0][WORD_W-1:0] taps;
    window_t            win;
    pix_t [LANES-1:0]   lane_mag;
    logic [LANES-1:0][DIR_W-1:0] lane_dir;

    // Step decode: a real word or a drain step with zero data.
    always_comb begin
        take_sof  = in_valid && in_sof && !flushing;
        step      = flushing || in_valid;
        step_data = flushing ? '0 : in_data;
        cur_col   = take_sof ? '0 : pos_col;
        cur_row   = take_sof ? '0 : pos_row;
        lag_now   = take_sof ? '0 : lag;
        emit      = step && (lag_now == LAG_FULL);
        last_in   = step && !flushing && (cur_row == LAST_ROW) && (cur_col == LAST_COL);
    end

    // Position of the next accepted word in the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_col <= '0;
            pos_row <= '0;
        end else if (step) begin
            if (cur_col == LAST_COL) begin
                pos_col <= '0;
                pos_row <= (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
            end else begin
                pos_col <= cur_col + 1'b1;
                pos_row <= cur_row;
            end
        end
    end

    // Words accepted since frame start, saturating at one line plus one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag <= '0;
        end else if (step) begin
            lag <= (lag_now == LAG_FULL) ? LAG_FULL : lag_now + 1'b1;
        end
    end

    // Position of the centre word of the next result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_col <= '0;
            cen_row <= '0;
        end else if (take_sof) begin
            cen_col <= '0;
            cen_row <= '0;
        end else if (emit) begin
            if (cen_col == LAST_COL) begin
                cen_col <= '0;
                cen_row <= (cen_row == LAST_ROW) ? '0 : cen_row + 1'b1;
            end else begin
                cen_col <= cen_col + 1'b1;
            end
        end
    end

    // Drain sequencer: one line plus one word of zero steps after a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flushing  <= 1'b0;
            drain_cnt <= '0;
        end else if (last_in) begin
            flushing  <= 1'b1;
            drain_cnt <= '0;
        end else if (flushing) begin
            flushing  <= (drain_cnt != DRAIN_END);
            drain_cnt <= drain_cnt + 1'b1;
        end
    end

    s4_line_cache #(
        .LINE_WORDS  (LINE_WORDS),
        .CACHED_LINES(WIN_ROWS - 1)
    ) i_cache (
        .clk (clk),
        .step(step),
        .addr(cur_col),
        .din (step_data),
        .taps(taps)
    );

    s4_window i_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .taps       (taps),
        .zero_left  (cen_col == '0),
        .zero_right (cen_col == LAST_COL),
        .zero_top   (cen_row == '0),
        .zero_bottom(cen_row == LAST_ROW),
        .win        (win)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pix_t [2:0][2:0] nb;
        for (genvar r = 0; r < 3; r++) begin : g_row
            for (genvar c = 0; c < 3; c++) begin : g_col
                assign nb[r][c] = win[r][k+c];
            end
        end
        s4_grad_px i_px (
            .nb (nb),
            .mag(lane_mag[k]),
            .dir(lane_dir[k])
        );
    end

    // Output register: strobes every cycle, data only on a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_mag   <= '0;
            out_dir   <= '0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit && (cen_col == '0) && (cen_row == '0);
            out_sol   <= emit && (cen_col == '0);
            if (emit) begin
                out_mag <= lane_mag;
                out_dir <= lane_dir;
            end
        end
    end
endmodule

// File: rtl/sobel4_gradient_chk.sv
// Temporal checks on the gradient stage, bound into every instance.
module sobel4_gradient_chk
    import sobel4_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_sof,
    input logic                   flushing,
    input logic                   out_valid,
    input logic                   out_sof,
    input logic                   out_sol,
    input logic [WORD_W-1:0]      out_mag,
    input logic [LANES*DIR_W-1:0] out_dir
);
    // R6: a result follows only a step.
    p_result_needs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid || flushing));

    // R6: no result in the cycle after a frame-start word.
    p_quiet_after_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_sof && !flushing) |-> !out_valid);

    // R7: drain cycles keep producing results.
    p_drain_emits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flushing && $past(flushing)) |-> out_valid);

    // R8: frame start implies line start and a valid result.
    p_sof_with_sol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_sol));

    // R8: line start only with a valid result.
    p_sol_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R5: a zero gradient falls in the same-sign diagonal sector.
    for (genvar k = 0; k < LANES; k++) begin : g_flat
        p_flat_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && (out_mag[PIX_W*k +: PIX_W] == '0))
                |-> (out_dir[DIR_W*k +: DIR_W] == 2'd1));
    end
endmodule

bind sobel4_gradient sobel4_gradient_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .flushing (flushing),
    .out_valid(out_valid),
    .out_sof  (out_sof),
    .out_sol  (out_sol),
    .out_mag  (out_mag),
    .out_dir  (out_dir)
);

// File: tb/test_sobel4_gradient.sv
// Bench: behavioural per-pixel reference, compared on every clock.
module test_sobel4_gradient;
    localparam int LW  = 8;
    localparam int FL  = 6;
    localparam int NPX = LW * 4;
    localparam int NW  = LW * FL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid, out_sof, out_sol;
    logic [31:0] out_mag;
    logic [7:0]  out_dir;

    always #10 clk = ~clk;

    sobel4_gradient #(.LINE_WORDS(LW), .FRAME_LINES(FL)) i_sobel4_gradient (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_sol(out_sol), .out_mag(out_mag), .out_dir(out_dir)
    );

    int          img [FL][NPX];
    logic [31:0] q_mag [$];
    logic [7:0]  q_dir [$];
    bit          q_sof [$];
    bit          q_sol [$];
    int          n_vec = 0;
    int          n_bad = 0;
    int          sent = 0;
    int          frame_outs = 0;
    bit          no_gaps = 1'b1;
    bit          frame_active = 1'b0;
    bit          last_idle = 1'b0;
    int unsigned seed = 32'd7;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int px(input int r, input int c);
        if (r < 0 || r >= FL || c < 0 || c >= NPX) return 0;
        return img[r][c];
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic fill(input int pattern);
        for (int r = 0; r < FL; r++) begin
            for (int c = 0; c < NPX; c++) begin
                case (pattern)
                    0: begin
                        seed = seed * 32'd1103515245 + 32'd12345;
                        img[r][c] = int'((seed >> 16) & 32'hFF);
                    end
                    1: img[r][c] = 255;
                    2: img[r][c] = (c < 13) ? 10 : 200;
                    3: img[r][c] = (r < 3) ? 0 : 180;
                    default: img[r][c] = ((r + c) * 9 > 255) ? 255 : (r + c) * 9;
                endcase
            end
        end
    endtask

    // Reference per requirement text (R2 to R5, R8).
    task automatic build_expected();
        for (int w = 0; w < NW; w++) begin
            int r;
            int cw;
            logic [31:0] m;
            logic [7:0]  d;
            r = w / LW;
            cw = w % LW;
            for (int k = 0; k < 4; k++) begin
                int c, gx, gy, ax, ay, s, sec;
                c  = cw * 4 + k;
                gx = (px(r-1,c+1) + 2*px(r,c+1) + px(r+1,c+1))
                   - (px(r-1,c-1) + 2*px(r,c-1) + px(r+1,c-1));
                gy = (px(r+1,c-1) + 2*px(r+1,c) + px(r+1,c+1))
                   - (px(r-1,c-1) + 2*px(r-1,c) + px(r-1,c+1));
                ax = iabs(gx);
                ay = iabs(gy);
                s  = (ax + ay > 255) ? 255 : ax + ay;
                if (309 * ay < 128 * ax) sec = 0;
                else if (53 * ay > 128 * ax) sec = 2;
                else if ((gx < 0) == (gy < 0)) sec = 1;
                else sec = 3;
                m[8*k +: 8] = 8'(s);
                d[2*k +: 2] = 2'(sec);
            end
            q_mag.push_back(m);
            q_dir.push_back(d);
            q_sof.push_back(w == 0);
            q_sol.push_back(cw == 0);
        end
    endtask

    // Monitor: compare every result against the reference queue.
    always @(negedge clk) begin
        if (rst_n && frame_active) begin
            if (sent == NW && frame_outs < NW)
                check(out_valid == 1'b1, "R7 drain result missing", longint'(out_valid), 1);
            if (!no_gaps && last_idle && sent < NW)
                check(out_valid == 1'b0, "R9 result after idle cycle", longint'(out_valid), 0);
            if (out_valid) begin
                if (q_mag.size() == 0) begin
                    check(1'b0, "R6 extra result", 1, 0);
                end else begin
                    logic [31:0] em;
                    logic [7:0]  ed;
                    bit es, el;
                    em = q_mag.pop_front();
                    ed = q_dir.pop_front();
                    es = q_sof.pop_front();
                    el = q_sol.pop_front();
                    check(out_mag == em, no_gaps ? "R1 R2 R3 R4 magnitude" : "R9 R4 magnitude",
                          longint'(out_mag), longint'(em));
                    check(out_dir == ed, no_gaps ? "R5 sector" : "R9 R5 sector",
                          longint'(out_dir), longint'(ed));
                    check(out_sof == es && out_sol == el, "R8 strobes",
                          longint'({out_sof, out_sol}), longint'({es, el}));
                    if (no_gaps && sent < NW)
                        check(sent == frame_outs + LW + 2, "R6 latency",
                              longint'(sent), longint'(frame_outs + LW + 2));
                end
                frame_outs++;
            end
        end
    end

    task automatic send_frame(input int pattern, input bit gaps);
        fill(pattern);
        build_expected();
        sent = 0;
        frame_outs = 0;
        no_gaps = !gaps;
        frame_active = 1'b1;
        for (int w = 0; w < NW; w++) begin
            if (gaps && (w % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof = 1'b0;
                in_data = 32'hDEAD_BEEF;
                @(posedge clk);
                last_idle = 1'b1;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof = (w == 0);
            for (int k = 0; k < 4; k++)
                in_data[8*k +: 8] = 8'(img[w / LW][(w % LW) * 4 + k]);
            @(posedge clk);
            sent++;
            last_idle = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_data = '0;
        repeat (LW + 4) @(posedge clk);
        @(negedge clk);
        frame_active = 1'b0;
        check(frame_outs == NW, "R6 R7 results per frame", longint'(frame_outs), longint'(NW));
        check(q_mag.size() == 0, "R7 results left undelivered", longint'(q_mag.size()), 0);
        q_mag.delete();
        q_dir.delete();
        q_sof.delete();
        q_sol.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_sof == 1'b0 && out_sol == 1'b0, "R10 reset strobes",
              longint'({out_valid, out_sof, out_sol}), 0);
        check(out_mag == '0 && out_dir == '0, "R10 reset data",
              longint'({out_dir, out_mag}), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        send_frame(0, 1'b0);
        send_frame(1, 1'b0);
        send_frame(2, 1'b0);
        send_frame(3, 1'b0);
        send_frame(4, 1'b0);
        send_frame(0, 1'b1);
        send_frame(2, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule